// File: doc/BRIEF.md
# Timer Channel Event Flag Register

This block holds the event flags for one channel of a 16-bit timer. There are four capture/compare flags, one for each general register (A, B, C, D), and one counter-overflow flag. A flag is set by a hardware event. While a flag is set, its interrupt request line is high. The CPU sees the flags through an 8-bit register on a simple synchronous read/write port.

A flag can be cleared in two ways:
- **Software handshake.** The CPU reads the register while the flag is 1, then writes 0 to that bit.
- **Transfer-controller acknowledge.** A data-transfer controller can clear any of A to D. A DMA controller can clear only flag A. Each acknowledge path clears only when its enable qualifier allows it.

The overflow flag has no acknowledge path. Only the software handshake clears it.

For each general register, the timer supplies a compare-match strobe, a capture-load strobe and a mode bit. The mode bit picks which of the two strobes counts as that register's event. The timer also supplies a wrap strobe that pulses when the counter goes from 0xFFFF to 0x0000.

Top module: `tmr_status_flags`

## Requirements
- R1: After the active-low synchronous reset, all five flags are 0, the register reads 0xC0 and every interrupt request is low.
- R2: Bit 7 and bit 6 always read 1 and bit 5 always reads 0. A write of any value leaves these bits unchanged.
- R3: When a general register is in compare mode (its `capMode` bit is 0), a pulse on its `cmpMatch` bit sets that register's flag. The flag reads 1 on the cycle after the pulse. A `capLoad` pulse has no effect in this mode. Flag A to flag D sit at bit 0 to bit 3.
- R4: When a general register is in capture mode (its `capMode` bit is 1), a pulse on its `capLoad` bit sets its flag. A `cmpMatch` pulse has no effect in this mode.
- R5: A pulse on `wrapEvt` sets the overflow flag at bit 4.
- R6: Two write rules apply to the flag bits:
  - A write with a flag bit at 0 clears that flag, but only if a register read made since the previous write returned 1 for that bit.
  - Writing 1 to a flag bit never changes the flag.
- R7: Writing 0 to a flag clears nothing if no read since the last write returned 1 for that flag. Every write cancels all earlier reads for this purpose, so a second write after one read clears nothing.
- R8: For each of flags A to D, a `xferAck` pulse clears the flag when its `xferDisIrq` qualifier is 0. The pulse has no effect when the qualifier is 1. No `xferAck` affects the overflow flag.
- R9: A `dmaAck` pulse with `dmaAckEn` at 1 clears flag A and no other flag. With `dmaAckEn` at 0, the pulse has no effect.
- R10: When a set event and any clear request for the same flag occur in one cycle, the flag ends up set.
- R11: Each `irqReq` bit equals its flag bit in the register, in the same cycle, with no added delay.
- R12: Clearing a flag by an acknowledge also cancels an earlier read of 1 for that flag. If the flag is then set again, a write of 0 with no new read leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmpMatch | input | 4 | Compare-match strobes for general registers A (bit 0) to D (bit 3) |
| capLoad | input | 4 | Capture-load strobes for general registers A to D |
| capMode | input | 4 | Mode of each general register: 1 = capture, 0 = compare |
| wrapEvt | input | 1 | Counter wrap strobe (0xFFFF to 0x0000) |
| busSel | input | 1 | Register select |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Register read value |
| xferAck | input | 4 | Data-transfer controller acknowledges for flags A to D |
| xferDisIrq | input | 4 | Disable-interrupt qualifier for each transfer acknowledge |
| dmaAck | input | 1 | DMA controller acknowledge for flag A |
| dmaAckEn | input | 1 | Enable qualifier for the DMA acknowledge |
| irqReq | output | 5 | Interrupt requests: bits 0 to 3 = flags A to D, bit 4 = overflow |

## Verification
The set path is swept for every general register over all eight combinations of mode, compare strobe and capture strobe. This shows that each flag reacts only to the strobe its mode selects, and only at its own bit position.

The clear path is tried with four kinds of writes:
- a write of 0 after a read of 1;
- a write of 1;
- a write of 0 with no read;
- a second write after a single read.

These separate a true handshake from a plain write-to-clear.

Each acknowledge is applied once with its qualifier blocking and once with it allowing. This shows which flags each path reaches and confirms that the overflow flag ignores all of them.

The remaining cases cover a set event in the same cycle as a clear, and a read that is cancelled by an acknowledge.

// File: rtl/tmr_stat_pkg.sv
package tmr_stat_pkg;
  localparam int NUM_GR  = 4;
  localparam int FLAG_W  = NUM_GR + 1;
  localparam int OVF_BIT = NUM_GR;
  localparam int REG_W   = 8;
  localparam int PAD_W   = REG_W - FLAG_W;
  localparam logic [PAD_W-1:0] PAD_BITS = 3'b110;

  typedef struct packed {
    logic [FLAG_W-1:0] setMask;
    logic [FLAG_W-1:0] clrMask;
  } flagStrobes_t;
endpackage

// File: rtl/tmr_stat_ctrl.sv
module tmr_stat_ctrl
  import tmr_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_GR-1:0] cmpMatch,
  input  logic [NUM_GR-1:0] capLoad,
  input  logic [NUM_GR-1:0] capMode,
  input  logic              wrapEvt,
  input  logic              busSel,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic [NUM_GR-1:0] xferAck,
  input  logic [NUM_GR-1:0] xferDisIrq,
  input  logic              dmaAck,
  input  logic              dmaAckEn,
  input  logic [FLAG_W-1:0] flagQ,
  output flagStrobes_t      strb
);
  logic [FLAG_W-1:0] armedQ;
  logic [FLAG_W-1:0] setVec;
  logic [FLAG_W-1:0] hwClr;
  logic [FLAG_W-1:0] swClr;
  logic              wrHit;
  logic              rdHit;

  assign wrHit = busSel & busWr;
  assign rdHit = busSel & busRd;

  for (genvar g = 0; g < NUM_GR; g++) begin : g_gr
    // mode picks which strobe counts as this register's event
    assign setVec[g] = capMode[g] ? capLoad[g] : cmpMatch[g];
    if (g == 0) begin : g_dma
      assign hwClr[g] = (xferAck[g] & ~xferDisIrq[g]) | (dmaAck & dmaAckEn);
    end else begin : g_plain
      assign hwClr[g] = xferAck[g] & ~xferDisIrq[g];
    end
  end

  assign setVec[OVF_BIT] = wrapEvt;
  assign hwClr[OVF_BIT]  = 1'b0;

  assign swClr = wrHit ? (~busWdata[FLAG_W-1:0] & armedQ) : '0;

  assign strb.setMask = setVec;
  assign strb.clrMask = swClr | hwClr;

  // read-as-one latch: armed by a read, consumed by any write or flag clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ <= '0;
    end else if (wrHit) begin
      armedQ <= '0;
    end else if (rdHit) begin
      armedQ <= (armedQ | flagQ) & ~hwClr;
    end else begin
      armedQ <= armedQ & ~hwClr;
    end
  end
endmodule

// File: rtl/tmr_stat_dp.sv
module tmr_stat_dp
  import tmr_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobes_t      strb,
  output logic [FLAG_W-1:0] flagQ,
  output logic [REG_W-1:0]  readVal
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
    end else begin
      flagQ <= strb.setMask | (flagQ & ~strb.clrMask);
    end
  end

  assign readVal = {PAD_BITS, flagQ};
endmodule

// File: rtl/tmr_status_flags.sv
module tmr_status_flags
  import tmr_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_GR-1:0] cmpMatch,
  input  logic [NUM_GR-1:0] capLoad,
  input  logic [NUM_GR-1:0] capMode,
  input  logic              wrapEvt,
  input  logic              busSel,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  logic [NUM_GR-1:0] xferAck,
  input  logic [NUM_GR-1:0] xferDisIrq,
  input  logic              dmaAck,
  input  logic              dmaAckEn,
  output logic [FLAG_W-1:0] irqReq
);
  flagStrobes_t      strb;
  logic [FLAG_W-1:0] flagQ;

  tmr_stat_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cmpMatch(cmpMatch), .capLoad(capLoad),
    .capMode(capMode), .wrapEvt(wrapEvt), .busSel(busSel), .busRd(busRd),
    .busWr(busWr), .busWdata(busWdata), .xferAck(xferAck),
    .xferDisIrq(xferDisIrq), .dmaAck(dmaAck), .dmaAckEn(dmaAckEn),
    .flagQ(flagQ), .strb(strb)
  );

  tmr_stat_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .flagQ(flagQ), .readVal(busRdata)
  );

  assign irqReq = flagQ;
endmodule

// File: rtl/tmr_status_chk.sv
module tmr_status_chk
  import tmr_stat_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [NUM_GR-1:0] cmpMatch,
  input logic [NUM_GR-1:0] capLoad,
  input logic [NUM_GR-1:0] capMode,
  input logic              wrapEvt,
  input logic              busSel,
  input logic              busRd,
  input logic              busWr,
  input logic [REG_W-1:0]  busWdata,
  input logic [REG_W-1:0]  busRdata,
  input logic [NUM_GR-1:0] xferAck,
  input logic [NUM_GR-1:0] xferDisIrq,
  input logic              dmaAck,
  input logic              dmaAckEn,
  input logic [FLAG_W-1:0] irqReq
);
  a_r2_pad_bits: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[REG_W-1:FLAG_W] == PAD_BITS);

  a_r3_compare_sets: assert property (@(posedge clk) disable iff (!rstN)
    (!capMode[0] && cmpMatch[0]) |=> irqReq[0]);

  a_r4_capture_sets: assert property (@(posedge clk) disable iff (!rstN)
    (capMode[1] && capLoad[1]) |=> irqReq[1]);

  a_r5_wrap_sets: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvt |=> irqReq[OVF_BIT]);

  a_r6_ovf_only_by_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqReq[OVF_BIT]) |-> $past(busSel && busWr && !busWdata[OVF_BIT]));

  a_r8_disabled_ack_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq[2] && xferDisIrq[2] && !(busSel && busWr)) |=> irqReq[2]);

  a_r9_dma_clears_a: assert property (@(posedge clk) disable iff (!rstN)
    (dmaAck && dmaAckEn && !(capMode[0] ? capLoad[0] : cmpMatch[0])) |=> !irqReq[0]);
endmodule

bind tmr_status_flags tmr_status_chk i_chk (
  .clk(clk), .rstN(rstN), .cmpMatch(cmpMatch), .capLoad(capLoad),
  .capMode(capMode), .wrapEvt(wrapEvt), .busSel(busSel), .busRd(busRd),
  .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata), .xferAck(xferAck),
  .xferDisIrq(xferDisIrq), .dmaAck(dmaAck), .dmaAckEn(dmaAckEn), .irqReq(irqReq)
);

// File: tb/test_tmr_status_flags.sv
module test_tmr_status_flags;
  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] cmpMatch, capLoad, capMode, xferAck, xferDisIrq;
  logic       wrapEvt, busSel, busRd, busWr, dmaAck, dmaAckEn;
  logic [7:0] busWdata, busRdata;
  logic [4:0] irqReq;
  int vectors = 0;
  int errs = 0;

  always #5 clk = ~clk;

  tmr_status_flags i_tmr_status_flags (
    .clk(clk), .rstN(rstN), .cmpMatch(cmpMatch), .capLoad(capLoad),
    .capMode(capMode), .wrapEvt(wrapEvt), .busSel(busSel), .busRd(busRd),
    .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata), .xferAck(xferAck),
    .xferDisIrq(xferDisIrq), .dmaAck(dmaAck), .dmaAckEn(dmaAckEn), .irqReq(irqReq)
  );

  task automatic chk(input string req, input logic [7:0] exp);
    vectors++;
    if (busRdata !== exp || irqReq !== exp[4:0]) begin
      errs++;
      $display("FAIL %s: rdata=%h irq=%h expected %h", req, busRdata, irqReq, exp);
    end
  endtask

  task automatic idle();
    cmpMatch = 0; capLoad = 0; capMode = 0; xferAck = 0; xferDisIrq = 0;
    wrapEvt = 0; busSel = 0; busRd = 0; busWr = 0; dmaAck = 0; dmaAckEn = 0;
    busWdata = 0;
  endtask

  task automatic doRead();
    busSel = 1; busRd = 1;
    @(negedge clk);
    busSel = 0; busRd = 0;
  endtask

  task automatic doWrite(input logic [7:0] d);
    busSel = 1; busWr = 1; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0; busWdata = 0;
  endtask

  task automatic setAll();
    capMode = 0; cmpMatch = 4'hF; wrapEvt = 1;
    @(negedge clk);
    cmpMatch = 0; wrapEvt = 0;
  endtask

  task automatic clearAll();
    doRead();
    doWrite(8'h00);
  endtask

  initial begin
    #(200000 * 10);
    errs++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    chk("R1 reset", 8'hC0);

    doWrite(8'hFF);
    chk("R2 pad write ignored", 8'hC0);

    // R3/R4 sweep: every register, mode, strobe pair
    for (int g = 0; g < 4; g++) begin
      for (int c = 0; c < 8; c++) begin
        logic m, cm, cl, s;
        m = c[2]; cm = c[1]; cl = c[0];
        s = m ? cl : cm;
        clearAll();
        capMode[g] = m; cmpMatch[g] = cm; capLoad[g] = cl;
        @(negedge clk);
        idle();
        chk(m ? "R4 capture set" : "R3 compare set", 8'hC0 | (8'(s) << g));
      end
    end

    clearAll();
    wrapEvt = 1;
    @(negedge clk);
    wrapEvt = 0;
    chk("R5 wrap set", 8'hD0);

    setAll();
    chk("R11 all flags", 8'hDF);
    doWrite(8'hFF);
    chk("R6 write one keeps", 8'hDF);
    doRead();
    doWrite(8'hFE);
    chk("R6 handshake clears A", 8'hDE);

    doWrite(8'h00);
    chk("R7 no read no clear", 8'hDE);
    doRead();
    doWrite(8'hFF);
    doWrite(8'h00);
    chk("R7 read consumed by write", 8'hDE);

    for (int g = 0; g < 4; g++) begin
      clearAll();
      setAll();
      xferAck[g] = 1; xferDisIrq[g] = 1;
      @(negedge clk);
      idle();
      chk("R8 ack disabled", 8'hDF);
      xferAck[g] = 1; xferDisIrq[g] = 0;
      @(negedge clk);
      idle();
      chk("R8 ack clears", 8'hDF & ~(8'h01 << g));
    end
    setAll();
    xferAck = 4'hF;
    @(negedge clk);
    idle();
    chk("R8 overflow immune", 8'hD0);

    setAll();
    dmaAck = 1; dmaAckEn = 0;
    @(negedge clk);
    idle();
    chk("R9 dma disabled", 8'hDF);
    dmaAck = 1; dmaAckEn = 1;
    @(negedge clk);
    idle();
    chk("R9 dma clears A only", 8'hDE);

    setAll();
    doRead();
    busSel = 1; busWr = 1; busWdata = 8'h00;
    cmpMatch[1] = 1; wrapEvt = 1;
    @(negedge clk);
    idle();
    chk("R10 set beats sw clear", 8'hD2);
    cmpMatch[1] = 1; xferAck[1] = 1;
    @(negedge clk);
    idle();
    chk("R10 set beats ack", 8'hD2);

    clearAll();
    cmpMatch[0] = 1;
    @(negedge clk);
    idle();
    doRead();
    xferAck[0] = 1;
    @(negedge clk);
    idle();
    chk("R12 ack cleared", 8'hC0);
    cmpMatch[0] = 1;
    @(negedge clk);
    idle();
    doWrite(8'h00);
    chk("R12 ack cancels read", 8'hC1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule